// File: doc/BRIEF.md
# Network Adapter Configuration Register Slice

This block holds a handful of fields from a type-0 PCI configuration header for a network adapter function. It contains a 32-byte memory window base, an expansion ROM base with a decode enable, and the dword that packs the interrupt routing byte, the fixed interrupt pin, and the minimum-grant and maximum-latency bytes. The host reaches these fields through a simple configuration port. That port carries a dword index, four byte enables, write data, a write strobe, a read strobe and a registered read-data bus. Every other dword index reads back as zero.

At power-up, a separate EEPROM reader signals once that it has finished. It does this with a done strobe, a present flag and two byte values. If an EEPROM is present, the grant and latency bytes take the values it supplied. If none is present, they keep fixed defaults. The low nibble of the interrupt routing byte is driven out continuously to neighbouring control logic. Two compare outputs tell address decode logic whether a probed address falls inside the memory window or inside the enabled ROM window.

Top module: `pcicfg_slice`

## Requirements
- R1: After reset, every readable dword returns zero except dword index 0x0F, which returns 0x0001_0100. `cfg_rdata` is loaded on the clock edge where `cfg_rd` is high and holds its value otherwise.
- R2: The memory base register sits at dword index 0x05. Bits 31:5 are writable and bits 4:0 always read as zero.
- R3: The ROM base register sits at dword index 0x0C. Only bits 31:16 and bit 0 (decode enable) are writable, and all other bits read as zero. Both fields reset to zero.
- R4: The interrupt routing byte is bits 7:0 of dword 0x0F. It is read/write, and its bits 3:0 drive `irq_nib` from the cycle after the write edge.
- R5: Bits 15:8 of dword 0x0F always read 0x01. Host writes leave bits 31:8 of dword 0x0F unchanged.
- R6: A write changes only the byte lanes whose `cfg_be` bit is set (lane n is bits 8n+7:8n), further limited by the register's writable bits.
- R7: On the first `ee_done` pulse after reset with `ee_present` high, bits 31:24 of dword 0x0F take `ee_maxlat` and bits 23:16 take `ee_mingnt`.
- R8: With no EEPROM, latency reads 0x00 and grant reads 0x01. Any `ee_done` pulse after the first one is ignored.
- R9: `mem_hit` is high exactly when `probe_addr[31:5]` equals the memory base bits 31:5.
- R10: `rom_hit` is high exactly when the decode enable is set and `probe_addr[31:16]` equals ROM base bits 31:16.
- R11: Dword indices other than 0x05, 0x0C and 0x0F read zero, and writes to them change nothing.
- R12: A read and a write to the same dword on the same edge return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 32 | Registered read data |
| ee_present | input | 1 | EEPROM found flag, valid with ee_done |
| ee_done | input | 1 | One-cycle EEPROM load complete strobe |
| ee_maxlat | input | 8 | Latency byte from EEPROM |
| ee_mingnt | input | 8 | Grant byte from EEPROM |
| irq_nib | output | 4 | Low nibble of the interrupt routing byte |
| probe_addr | input | 32 | Address to compare against the windows |
| mem_hit | output | 1 | Probe falls inside the memory window |
| rom_hit | output | 1 | Probe falls inside the enabled ROM window |

## Verification
Two pairs of events can land on the same edge. The first pair is a host write to dword 0x0F and the EEPROM done strobe. The bench raises both together with all byte enables set, then expects the routing byte to come from the host and the latency and grant bytes to come from the EEPROM. The second pair is a read and a write to the same dword on one edge. The random phase issues such combined accesses and expects the read to return the model's contents from before the write, while a later read shows the merged value.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  localparam int unsigned IDX_W     = 6;
  localparam int unsigned DW        = 32;
  localparam int unsigned LANES     = DW / 8;

  localparam logic [IDX_W-1:0] IDX_MEMWIN = 6'h05;
  localparam logic [IDX_W-1:0] IDX_ROMWIN = 6'h0C;
  localparam logic [IDX_W-1:0] IDX_INTDW  = 6'h0F;

  localparam logic [DW-1:0] MEMWIN_WMASK = 32'hFFFF_FFE0;
  localparam logic [DW-1:0] ROMWIN_WMASK = 32'hFFFF_0001;
  localparam logic [DW-1:0] ROMWIN_CMASK = 32'hFFFF_0000;

  localparam logic [7:0] PIN_CODE    = 8'h01;
  localparam logic [7:0] GNT_DEFAULT = 8'h01;
  localparam logic [7:0] LAT_DEFAULT = 8'h00;

  // Merge one byte lane: bits set in m take the new value.
  function automatic logic [7:0] lane_merge(input logic [7:0] old_v,
                                            input logic [7:0] new_v,
                                            input logic [7:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  // True when a and b agree on every bit selected by m.
  function automatic logic window_match(input logic [DW-1:0] a,
                                        input logic [DW-1:0] b,
                                        input logic [DW-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  // Pack the interrupt dword in the header byte order.
  function automatic logic [DW-1:0] pack_intdw(input logic [7:0] line,
                                               input logic [7:0] gnt,
                                               input logic [7:0] lat);
    return {lat, gnt, PIN_CODE, line};
  endfunction
endpackage

// File: rtl/pcicfg_maskreg.sv
module pcicfg_maskreg #(
  parameter int unsigned W     = 32,
  parameter logic [W-1:0] WMASK = '1,
  parameter logic [W-1:0] RSTV  = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [W/8-1:0] be,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   q
);
  import pcicfg_pkg::*;
  localparam int unsigned NL = W / 8;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    localparam logic [7:0] LMASK = WMASK[8*g +: 8];
    localparam logic [7:0] LRST  = RSTV[8*g +: 8];
    if (LMASK == 8'h00) begin : g_fixed
      assign q[8*g +: 8] = LRST;
    end else begin : g_rw
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          lane_q <= LRST;
        else if (we && be[g])
          lane_q <= lane_merge(lane_q, wdata[8*g +: 8], LMASK);
      end
      assign q[8*g +: 8] = lane_q;
    end
  end
endmodule

// File: rtl/pcicfg_eeload.sv
module pcicfg_eeload (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ee_done,
  input  logic       ee_present,
  input  logic [7:0] ee_maxlat,
  input  logic [7:0] ee_mingnt,
  output logic [7:0] lat_q,
  output logic [7:0] gnt_q,
  output logic       loaded
);
  import pcicfg_pkg::*;
  logic take;
  assign take = ee_done && !loaded;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q  <= LAT_DEFAULT;
      gnt_q  <= GNT_DEFAULT;
      loaded <= 1'b0;
    end else if (take) begin
      loaded <= 1'b1;
      if (ee_present) begin
        lat_q <= ee_maxlat;
        gnt_q <= ee_mingnt;
      end
    end
  end
endmodule

// File: rtl/pcicfg_decode.sv
module pcicfg_decode (
  input  logic [31:0] probe_addr,
  input  logic [31:0] memwin_q,
  input  logic [31:0] romwin_q,
  output logic        mem_hit,
  output logic        rom_hit
);
  import pcicfg_pkg::*;
  assign mem_hit = window_match(probe_addr, memwin_q, MEMWIN_WMASK);
  assign rom_hit = romwin_q[0] && window_match(probe_addr, romwin_q, ROMWIN_CMASK);
endmodule

// File: rtl/pcicfg_slice.sv
module pcicfg_slice (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  output logic [31:0] cfg_rdata,
  input  logic        ee_present,
  input  logic        ee_done,
  input  logic [7:0]  ee_maxlat,
  input  logic [7:0]  ee_mingnt,
  output logic [3:0]  irq_nib,
  input  logic [31:0] probe_addr,
  output logic        mem_hit,
  output logic        rom_hit
);
  import pcicfg_pkg::*;

  logic        we_mem, we_rom, we_int;
  logic [31:0] memwin_q, romwin_q, rd_mux;
  logic [7:0]  line_q, lat_q, gnt_q;
  logic        ee_loaded;

  assign we_mem = cfg_wr && (cfg_addr == IDX_MEMWIN);
  assign we_rom = cfg_wr && (cfg_addr == IDX_ROMWIN);
  assign we_int = cfg_wr && (cfg_addr == IDX_INTDW);

  pcicfg_maskreg #(.W(32), .WMASK(MEMWIN_WMASK), .RSTV(32'h0)) u_memwin (
    .clk(clk), .rst_n(rst_n), .we(we_mem), .be(cfg_be), .wdata(cfg_wdata), .q(memwin_q));

  pcicfg_maskreg #(.W(32), .WMASK(ROMWIN_WMASK), .RSTV(32'h0)) u_romwin (
    .clk(clk), .rst_n(rst_n), .we(we_rom), .be(cfg_be), .wdata(cfg_wdata), .q(romwin_q));

  pcicfg_maskreg #(.W(8), .WMASK(8'hFF), .RSTV(8'h00)) u_line (
    .clk(clk), .rst_n(rst_n), .we(we_int), .be(cfg_be[0]), .wdata(cfg_wdata[7:0]), .q(line_q));

  pcicfg_eeload u_ee (
    .clk(clk), .rst_n(rst_n), .ee_done(ee_done), .ee_present(ee_present),
    .ee_maxlat(ee_maxlat), .ee_mingnt(ee_mingnt),
    .lat_q(lat_q), .gnt_q(gnt_q), .loaded(ee_loaded));

  pcicfg_decode u_dec (
    .probe_addr(probe_addr), .memwin_q(memwin_q), .romwin_q(romwin_q),
    .mem_hit(mem_hit), .rom_hit(rom_hit));

  always_comb begin
    unique case (cfg_addr)
      IDX_MEMWIN: rd_mux = memwin_q;
      IDX_ROMWIN: rd_mux = romwin_q;
      IDX_INTDW:  rd_mux = pack_intdw(line_q, gnt_q, lat_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_rdata <= '0;
    else if (cfg_rd)
      cfg_rdata <= rd_mux;
  end

  assign irq_nib = line_q[3:0];
endmodule

// File: rtl/pcicfg_checker.sv
module pcicfg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  cfg_addr,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic        cfg_wr,
  input logic        cfg_rd,
  input logic [31:0] cfg_rdata,
  input logic [3:0]  irq_nib,
  input logic        rom_hit,
  input logic        ee_done,
  input logic        ee_present,
  input logic [7:0]  ee_maxlat,
  input logic [7:0]  ee_mingnt,
  input logic [31:0] romwin_q,
  input logic [7:0]  lat_q,
  input logic [7:0]  gnt_q,
  input logic        ee_loaded
);
  assert_memwin_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_rd) && ($past(cfg_addr) == 6'h05) |-> cfg_rdata[4:0] == 5'h0);

  assert_romwin_full_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && (cfg_addr == 6'h0C) && (cfg_be == 4'hF)
    |=> romwin_q == ($past(cfg_wdata) & 32'hFFFF_0001));

  assert_irq_nib_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && (cfg_addr == 6'h0F) && cfg_be[0] |=> irq_nib == $past(cfg_wdata[3:0]));

  assert_pin_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_rd) && ($past(cfg_addr) == 6'h0F) |-> cfg_rdata[15:8] == 8'h01);

  assert_ee_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ee_done && !ee_loaded && ee_present
    |=> (lat_q == $past(ee_maxlat)) && (gnt_q == $past(ee_mingnt)));

  assert_ee_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ee_loaded |=> $stable(lat_q) && $stable(gnt_q) && ee_loaded);

  assert_rom_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit |-> romwin_q[0]);

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_rd) && ($past(cfg_addr) != 6'h05) && ($past(cfg_addr) != 6'h0C)
    && ($past(cfg_addr) != 6'h0F) |-> cfg_rdata == 32'h0);
endmodule

bind pcicfg_slice pcicfg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
  .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
  .irq_nib(irq_nib), .rom_hit(rom_hit), .ee_done(ee_done), .ee_present(ee_present),
  .ee_maxlat(ee_maxlat), .ee_mingnt(ee_mingnt), .romwin_q(romwin_q),
  .lat_q(lat_q), .gnt_q(gnt_q), .ee_loaded(ee_loaded));

// File: tb/sim_pcicfg_slice.sv
`timescale 1ns/1ps
module sim_pcicfg_slice;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_wr, cfg_rd;
  logic [31:0] cfg_rdata;
  logic        ee_present, ee_done;
  logic [7:0]  ee_maxlat, ee_mingnt;
  logic [3:0]  irq_nib;
  logic [31:0] probe_addr;
  logic        mem_hit, rom_hit;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model
  logic [31:0] m_mem, m_rom;
  logic [7:0]  m_line, m_lat, m_gnt;
  bit          m_done;

  always #2.5 clk = ~clk;

  pcicfg_slice u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [5:0] a);
    case (a)
      6'h05:   return {m_mem[31:5], 5'b0};
      6'h0C:   return {m_rom[31:16], 15'b0, m_rom[0]};
      6'h0F:   return {m_lat, m_gnt, 8'h01, m_line};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] lanes(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] b, input logic [31:0] keep);
    logic [31:0] r = o;
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 8; j++)
        if (b[k] && keep[8*k+j]) r[8*k+j] = n[8*k+j];
    return r;
  endfunction

  task automatic model_write(input logic [5:0] a, input logic [3:0] b, input logic [31:0] d);
    if (a == 6'h05) m_mem = lanes(m_mem, d, b, 32'hFFFF_FFE0);
    if (a == 6'h0C) m_rom = lanes(m_rom, d, b, 32'hFFFF_0001);
    if (a == 6'h0F && b[0]) m_line = d[7:0];
  endtask

  task automatic do_reset();
    rst_n = 0; cfg_wr = 0; cfg_rd = 0; ee_done = 0; ee_present = 0;
    cfg_addr = 0; cfg_be = 0; cfg_wdata = 0; ee_maxlat = 0; ee_mingnt = 0; probe_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    m_mem = 0; m_rom = 0; m_line = 0; m_lat = 8'h00; m_gnt = 8'h01; m_done = 0;
  endtask

  // entered at a negedge; leaves at the following negedge
  task automatic access(input bit w, input bit r, input logic [5:0] a,
                        input logic [3:0] b, input logic [31:0] d, output logic [31:0] q);
    cfg_addr = a; cfg_be = b; cfg_wdata = d; cfg_wr = w; cfg_rd = r;
    @(posedge clk); @(negedge clk);
    cfg_wr = 0; cfg_rd = 0;
    q = cfg_rdata;
    if (w) model_write(a, b, d);
  endtask

  task automatic ee_pulse(input bit pres, input logic [7:0] lat, input logic [7:0] gnt);
    ee_present = pres; ee_maxlat = lat; ee_mingnt = gnt; ee_done = 1;
    @(posedge clk); @(negedge clk);
    ee_done = 0;
    if (!m_done && pres) begin m_lat = lat; m_gnt = gnt; end
    m_done = 1;
  endtask

  task automatic probe(input logic [31:0] a);
    probe_addr = a; #1;
    chk("R9 mem_hit", {31'b0, mem_hit}, {31'b0, a[31:5] == m_mem[31:5]});
    chk("R10 rom_hit", {31'b0, rom_hit}, {31'b0, m_rom[0] && (a[31:16] == m_rom[31:16])});
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] q, exp, seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    do_reset();
    chk("R1 rdata reset", cfg_rdata, 32'h0);
    access(0, 1, 6'h05, 0, 0, q); chk("R1 mem reset", q, 32'h0);
    access(0, 1, 6'h0C, 0, 0, q); chk("R3 rom reset", q, 32'h0);
    access(0, 1, 6'h0F, 0, 0, q); chk("R1 intdw reset", q, 32'h0001_0100);
    chk("R1 rdata holds", cfg_rdata, 32'h0001_0100);
    // R2 / R3 masks, R6 lanes
    access(1, 0, 6'h05, 4'hF, 32'hFFFF_FFFF, q);
    access(0, 1, 6'h05, 0, 0, q); chk("R2 mem mask", q, 32'hFFFF_FFE0);
    access(1, 0, 6'h0C, 4'hF, 32'hFFFF_FFFF, q);
    access(0, 1, 6'h0C, 0, 0, q); chk("R3 rom mask", q, 32'hFFFF_0001);
    access(1, 0, 6'h05, 4'b0100, 32'h0000_0000, q);
    access(0, 1, 6'h05, 0, 0, q); chk("R6 one lane", q, 32'hFF00_FFE0);
    // R4 / R5
    access(1, 0, 6'h0F, 4'hF, 32'hA5C3_7E5B, q);
    chk("R4 irq_nib", {28'b0, irq_nib}, 32'hB);
    access(0, 1, 6'h0F, 0, 0, q); chk("R5 pin and ro", q, 32'h0001_015B);
    // R11
    access(1, 0, 6'h10, 4'hF, 32'hDEAD_BEEF, q);
    access(0, 1, 6'h10, 0, 0, q); chk("R11 unmapped", q, 32'h0);
    // R8 absent then ignored second strobe
    access(0, 1, 6'h0F, 0, 0, q); chk("R8 before done", q[31:16], 32'h0001);
    ee_pulse(0, 8'h44, 8'h55);
    access(0, 1, 6'h0F, 0, 0, q); chk("R8 absent", q[31:16], 32'h0001);
    ee_pulse(1, 8'h66, 8'h77);
    access(0, 1, 6'h0F, 0, 0, q); chk("R8 second strobe", q[31:16], 32'h0001);
    // R7 with concurrent host write
    do_reset();
    cfg_addr = 6'h0F; cfg_be = 4'hF; cfg_wdata = 32'h1122_3309; cfg_wr = 1;
    ee_pulse(1, 8'hC8, 8'h3A);
    cfg_wr = 0; model_write(6'h0F, 4'hF, 32'h1122_3309);
    access(0, 1, 6'h0F, 0, 0, q); chk("R7 load with write", q, 32'hC83A_0109);
    // R10 enable off
    access(1, 0, 6'h0C, 4'hC, 32'h1234_0000, q);
    probe(32'h1234_8000);
    access(1, 0, 6'h0C, 4'h1, 32'h0000_0001, q);
    probe(32'h1234_8000);
    probe(32'h1235_0000);
    // R12 directed
    access(1, 1, 6'h0C, 4'hF, 32'h0000_0000, q); chk("R12 old value", q, 32'h1234_0001);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [5:0] a;
      logic [3:0] b;
      logic [31:0] d;
      int op;
      op = int'($urandom % 4);
      case ($urandom % 4)
        0: a = 6'h05; 1: a = 6'h0C; 2: a = 6'h0F; default: a = 6'($urandom);
      endcase
      b = 4'($urandom); d = $urandom;
      case (op)
        0: access(1, 0, a, b, d, q);
        1: begin access(0, 1, a, b, d, q); chk("R6 read", q, model_read(a)); end
        2: begin exp = model_read(a); access(1, 1, a, b, d, q); chk("R12 same edge", q, exp); end
        default: begin
          if ($urandom % 2) probe({m_mem[31:5], 5'($urandom)});
          else if ($urandom % 2) probe({m_rom[31:16], 16'($urandom)});
          else probe($urandom);
          chk("R4 nib", {28'b0, irq_nib}, {28'b0, m_line[3:0]});
        end
      endcase
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule